// File: doc/BRIEF.md
# Multi-Mode Preset Counter with Event Flags

This block is a synchronous up/down event counter for a larger chip. Each clock cycle it may take one count strobe together with a direction bit. It steps a counter whose active width can be set to 1, 2, 3 or 4 bytes. A preset register gives the load value, the compare value and the bound or modulus of the counting behaviour in use. A snapshot register holds a copy of the counter that can be read while counting goes on. There are four counting behaviours: free-running, single-cycle, range-limit and modulo-n.

An index strobe can be set to do nothing, load the counter from the preset, clear the counter, or copy the counter into the snapshot. A status byte records carry, borrow, compare and index events. These event bits are sticky. The status byte also shows live enable, direction and sign bits, and a power-loss bit that is set at reset.

There are two active-low flag outputs. One stays low while any masked event bit is latched. The other pulses low for one cycle for each masked event. A host-side port writes, clears and loads the registers through single-cycle strobes, and can read them back on the outputs.

Top module: `preset_count_core`

## Requirements
- R1: After reset, the counter, preset, snapshot, mode byte and option byte read zero. The status byte reads 0x04 while `count_en` is low, the only set bit being power-loss (bit 2). Both flag outputs are high.
- R2: Option bits [1:0] set the active width: 00 = 4 bytes, 01 = 3 bytes, 10 = 2 bytes, 11 = 1 byte. The counter wraps at that width. A preset write keeps only the active bytes. Status bit 0 (sign) is the top bit of the active width of the counter.
- R3: Mode bits [3:2] = 00 is free-running. An up strobe adds 1 and a down strobe subtracts 1. Wrapping from all-ones to zero sets carry (status bit 7). Wrapping from zero to all-ones sets borrow (status bit 6).
- R4: Mode bits [3:2] = 01 is single-cycle. After a step that raises carry or borrow, every further count strobe is ignored until the counter is cleared or loaded.
- R5: Mode bits [3:2] = 10 is range-limit. An up strobe with the counter equal to the preset holds the counter and sets carry. A down strobe at zero holds the counter and sets borrow. A strobe in the opposite direction moves the counter again.
- R6: Mode bits [3:2] = 11 is modulo-n. Counting up from the preset value goes to zero and sets carry. Counting down from zero goes to the preset value and sets borrow.
- R7: Count strobes take effect only while `count_en` is high and option bit 2 is 0. Status bit 3 shows this enable condition.
- R8: Mode bits [5:4] choose the index action: 00 none, 01 load the counter from the preset, 10 clear the counter, 11 copy the counter into the snapshot. Any index strobe with a non-zero action sets status bit 4.
- R9: The host can clear the counter, load it from the preset, and copy it into the snapshot. When several updates hit the counter in the same cycle, the order of priority is: host clear, then host load, then index load/clear, then the count step.
- R10: Status bit 5 (compare) is set when a count step leaves the counter equal to the preset.
- R11: Status bits 7..4 and 2 are sticky and are cleared only by a status clear. The status clear wins over an event in the same cycle. Status bit 1 holds the direction of the last step (1 = up).
- R12: `latch_flag_n` is low while any status bit 7..4 is set whose enable bit is set. The enables are option bits 7, 6, 5 and 4, for carry, borrow, compare and index.
- R13: `pulse_flag_n` is low for exactly the one cycle that follows a clock edge at which an enabled event happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Counting enable pin |
| count_strobe | input | 1 | One count event this cycle |
| count_up | input | 1 | Direction of the count event (1 = up) |
| index_strobe | input | 1 | Index event this cycle |
| host_wdata | input | 32 | Write data for mode, option and preset writes |
| wr_mode | input | 1 | Write mode byte from host_wdata[7:0] |
| wr_opts | input | 1 | Write option byte from host_wdata[7:0] |
| wr_preset | input | 1 | Write preset, masked to the active width |
| clr_mode | input | 1 | Clear mode byte |
| clr_opts | input | 1 | Clear option byte |
| clr_count | input | 1 | Clear counter |
| clr_status | input | 1 | Clear sticky status bits |
| load_count | input | 1 | Load counter from preset |
| snap_count | input | 1 | Copy counter into snapshot |
| count_val | output | 32 | Counter, active width |
| preset_val | output | 32 | Preset register |
| snap_val | output | 32 | Snapshot register |
| status_val | output | 8 | Status byte |
| mode_val | output | 8 | Mode byte |
| opts_val | output | 8 | Option byte |
| latch_flag_n | output | 1 | Latched event flag, active low |
| pulse_flag_n | output | 1 | Per-event flag pulse, active low |

## Verification
The counter, preset, snapshot, status byte and latched flag all change at the same clock edge that samples a strobe, so their new values can be read at the falling edge that follows. The pulse flag is low between that edge and the next one and goes high again after it. The bench changes inputs only on falling edges and holds each strobe for one full cycle. It samples at the falling edge after the edge that acts, so every expected value falls in a known cycle. Each flag check is paired with a second sample one idle cycle later, which shows that the pulse has ended while the latched flag stays low.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAX_BYTES = 4;
  localparam int unsigned CNT_W     = BYTE_W * MAX_BYTES;
  localparam int unsigned SEL_W     = $clog2(MAX_BYTES);
  localparam int unsigned N_EVT     = 4;

  typedef logic [CNT_W-1:0] word_t;

  typedef enum logic [1:0] {
    CM_FREE   = 2'b00,
    CM_SINGLE = 2'b01,
    CM_RANGE  = 2'b10,
    CM_MODN   = 2'b11
  } count_mode_e;

  typedef enum logic [1:0] {
    IX_OFF   = 2'b00,
    IX_LOAD  = 2'b01,
    IX_CLEAR = 2'b10,
    IX_SNAP  = 2'b11
  } index_fn_e;

  typedef struct packed {
    word_t val;
    logic  carry;
    logic  borrow;
    logic  moved;
  } step_t;

  // Active-width mask: selector value k drops k top bytes.
  function automatic word_t width_mask(input logic [SEL_W-1:0] sel);
    return {CNT_W{1'b1}} >> (int'(sel) * BYTE_W);
  endfunction

  // Top bit of the active width.
  function automatic logic sign_of(input word_t v, input logic [SEL_W-1:0] sel);
    int idx;
    idx = (int'(MAX_BYTES) - int'(sel)) * int'(BYTE_W) - 1;
    return v[idx];
  endfunction

  // One count step under the selected counting behaviour.
  function automatic step_t next_count(input word_t cur, input word_t pre,
                                       input word_t msk, input count_mode_e md,
                                       input logic up);
    step_t r;
    r.val    = cur;
    r.carry  = 1'b0;
    r.borrow = 1'b0;
    r.moved  = 1'b1;
    if (up) begin
      if (md == CM_MODN && cur == pre) begin
        r.val   = '0;
        r.carry = 1'b1;
      end else if (md == CM_RANGE && cur == pre) begin
        r.moved = 1'b0;
        r.carry = 1'b1;
      end else begin
        r.val   = (cur + word_t'(1)) & msk;
        r.carry = (cur == msk);
      end
    end else begin
      if (md == CM_MODN && cur == '0) begin
        r.val    = pre;
        r.borrow = 1'b1;
      end else if (md == CM_RANGE && cur == '0) begin
        r.moved  = 1'b0;
        r.borrow = 1'b1;
      end else begin
        r.val    = (cur - word_t'(1)) & msk;
        r.borrow = (cur == '0);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pcc_cfg_regs.sv
module pcc_cfg_regs
  import pcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t wdata,
  input  logic  wr_mode,
  input  logic  wr_opts,
  input  logic  wr_preset,
  input  logic  clr_mode,
  input  logic  clr_opts,
  output logic [7:0] mode_q,
  output logic [7:0] opts_q,
  output word_t preset_q
);
  word_t cur_mask;
  assign cur_mask = width_mask(opts_q[SEL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      opts_q   <= '0;
      preset_q <= '0;
    end else begin
      if (clr_mode)     mode_q <= '0;
      else if (wr_mode) mode_q <= wdata[7:0];
      if (clr_opts)     opts_q <= '0;
      else if (wr_opts) opts_q <= wdata[7:0];
      if (wr_preset)    preset_q <= wdata & cur_mask;
    end
  end

  // R2: a written preset never carries bytes outside the width in force at the write
  assert_preset_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_preset |=> ((preset_q & ~width_mask($past(opts_q[SEL_W-1:0]))) == '0));
endmodule

// File: rtl/pcc_counter.sv
module pcc_counter
  import pcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        count_strobe,
  input  logic        count_up,
  input  logic        en_live,
  input  count_mode_e mode,
  input  index_fn_e   idx_fn,
  input  logic        index_strobe,
  input  logic        clr_count,
  input  logic        load_count,
  input  logic        snap_count,
  input  word_t       preset_m,
  input  word_t       wmask,
  output word_t       cnt_m,
  output word_t       snap_q,
  output logic        ev_carry,
  output logic        ev_borrow,
  output logic        ev_cmp,
  output logic        step_fire,
  output logic        halted
);
  word_t cnt_q;
  step_t step_res;
  logic  idx_hits_cnt;
  logic  cnt_override;
  logic  single_gate;

  assign cnt_m = cnt_q & wmask;

  always_comb begin
    step_res     = next_count(cnt_m, preset_m, wmask, mode, count_up);
    idx_hits_cnt = index_strobe && (idx_fn == IX_LOAD || idx_fn == IX_CLEAR);
    cnt_override = clr_count || load_count || idx_hits_cnt;
    single_gate  = (mode == CM_SINGLE) && halted;
    step_fire    = count_strobe && en_live && !single_gate && !cnt_override;
    ev_carry     = step_fire && step_res.carry;
    ev_borrow    = step_fire && step_res.borrow;
    ev_cmp       = step_fire && step_res.moved && (step_res.val == preset_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      halted <= 1'b0;
    end else begin
      if (clr_count)                                  cnt_q <= '0;
      else if (load_count)                            cnt_q <= preset_m;
      else if (index_strobe && idx_fn == IX_LOAD)     cnt_q <= preset_m;
      else if (index_strobe && idx_fn == IX_CLEAR)    cnt_q <= '0;
      else if (step_fire)                             cnt_q <= step_res.val;

      if (cnt_override)
        halted <= 1'b0;
      else if (step_fire && mode == CM_SINGLE && (step_res.carry || step_res.borrow))
        halted <= 1'b1;

      if (snap_count || (index_strobe && idx_fn == IX_SNAP))
        snap_q <= cnt_m;
    end
  end

  // R4: once halted in single-cycle mode the counter only moves by clear or load
  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_SINGLE && halted && !cnt_override) |=> $stable(cnt_q));

  // R5: in range-limit mode a counter at or below the preset stays there
  assert_range_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_RANGE && cnt_m <= preset_m) |=>
      (!$stable(preset_m) || !$stable(wmask) || cnt_m <= preset_m));
endmodule

// File: rtl/pcc_status.sv
module pcc_status
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_status,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] evt_mask,
  input  logic             step_fire,
  input  logic             step_up,
  input  logic             en_live,
  input  logic             sign,
  output logic [7:0]       status,
  output logic             latch_flag_n,
  output logic             pulse_flag_n
);
  logic [N_EVT-1:0] sticky_q;
  logic             power_lost_q;
  logic             dir_q;
  logic             pulse_q;

  for (genvar g = 0; g < N_EVT; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sticky_q[g] <= 1'b0;
      else if (clr_status) sticky_q[g] <= 1'b0;
      else if (evt[g])     sticky_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_lost_q <= 1'b1;
      dir_q        <= 1'b0;
      pulse_q      <= 1'b0;
    end else begin
      if (clr_status) power_lost_q <= 1'b0;
      if (step_fire)  dir_q <= step_up;
      pulse_q <= |(evt & evt_mask);
    end
  end

  assign status       = {sticky_q, en_live, power_lost_q, dir_q, sign};
  assign latch_flag_n = ~|(sticky_q & evt_mask);
  assign pulse_flag_n = ~pulse_q;

  // R11: a status clear wins over any same-cycle event
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> (status[7:4] == '0 && !status[2]));

  // R11: without a clear, no sticky bit ever falls
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> (($past(sticky_q) & ~sticky_q) == '0));

  // R13: a pulse that no clear cancelled goes with a latched flag
  assert_pulse_latch_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_flag_n && !$past(clr_status) && $stable(evt_mask)) |-> !latch_flag_n);
endmodule

// File: rtl/preset_count_core.sv
module preset_count_core
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             count_strobe,
  input  logic             count_up,
  input  logic             index_strobe,
  input  logic [CNT_W-1:0] host_wdata,
  input  logic             wr_mode,
  input  logic             wr_opts,
  input  logic             wr_preset,
  input  logic             clr_mode,
  input  logic             clr_opts,
  input  logic             clr_count,
  input  logic             clr_status,
  input  logic             load_count,
  input  logic             snap_count,
  output logic [CNT_W-1:0] count_val,
  output logic [CNT_W-1:0] preset_val,
  output logic [CNT_W-1:0] snap_val,
  output logic [7:0]       status_val,
  output logic [7:0]       mode_val,
  output logic [7:0]       opts_val,
  output logic             latch_flag_n,
  output logic             pulse_flag_n
);
  logic [7:0]       mode_q;
  logic [7:0]       opts_q;
  word_t            preset_q;
  word_t            wmask;
  word_t            preset_m;
  word_t            cnt_m;
  word_t            snap_q;
  logic             en_live;
  logic             ev_carry, ev_borrow, ev_cmp, ev_index;
  logic             step_fire;
  logic             halted;
  count_mode_e      cmode;
  index_fn_e        ifn;
  logic [N_EVT-1:0] evt;

  assign wmask    = width_mask(opts_q[SEL_W-1:0]);
  assign preset_m = preset_q & wmask;
  assign en_live  = count_en && !opts_q[2];
  assign cmode    = count_mode_e'(mode_q[3:2]);
  assign ifn      = index_fn_e'(mode_q[5:4]);
  assign ev_index = index_strobe && (ifn != IX_OFF);
  assign evt      = {ev_carry, ev_borrow, ev_cmp, ev_index};

  pcc_cfg_regs i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (host_wdata),
    .wr_mode   (wr_mode),
    .wr_opts   (wr_opts),
    .wr_preset (wr_preset),
    .clr_mode  (clr_mode),
    .clr_opts  (clr_opts),
    .mode_q    (mode_q),
    .opts_q    (opts_q),
    .preset_q  (preset_q)
  );

  pcc_counter i_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_strobe (count_strobe),
    .count_up     (count_up),
    .en_live      (en_live),
    .mode         (cmode),
    .idx_fn       (ifn),
    .index_strobe (index_strobe),
    .clr_count    (clr_count),
    .load_count   (load_count),
    .snap_count   (snap_count),
    .preset_m     (preset_m),
    .wmask        (wmask),
    .cnt_m        (cnt_m),
    .snap_q       (snap_q),
    .ev_carry     (ev_carry),
    .ev_borrow    (ev_borrow),
    .ev_cmp       (ev_cmp),
    .step_fire    (step_fire),
    .halted       (halted)
  );

  pcc_status i_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_status   (clr_status),
    .evt          (evt),
    .evt_mask     (opts_q[7:4]),
    .step_fire    (step_fire),
    .step_up      (count_up),
    .en_live      (en_live),
    .sign         (sign_of(cnt_m, opts_q[SEL_W-1:0])),
    .status       (status_val),
    .latch_flag_n (latch_flag_n),
    .pulse_flag_n (pulse_flag_n)
  );

  assign count_val  = cnt_m;
  assign preset_val = preset_q;
  assign snap_val   = snap_q;
  assign mode_val   = mode_q;
  assign opts_val   = opts_q;

  // R7: with counting disabled, a bare count strobe leaves the counter alone
  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_live && !clr_count && !load_count && !index_strobe && !wr_opts && !clr_opts)
      |=> $stable(cnt_m));
endmodule

// File: tb/test_preset_count_core.sv
module test_preset_count_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        count_strobe = 1'b0;
  logic        count_up = 1'b0;
  logic        index_strobe = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        wr_mode = 1'b0, wr_opts = 1'b0, wr_preset = 1'b0;
  logic        clr_mode = 1'b0, clr_opts = 1'b0, clr_count = 1'b0, clr_status = 1'b0;
  logic        load_count = 1'b0, snap_count = 1'b0;
  logic [31:0] count_val, preset_val, snap_val;
  logic [7:0]  status_val, mode_val, opts_val;
  logic        latch_flag_n, pulse_flag_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  preset_count_core i_preset_count_core (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .count_strobe(count_strobe),
    .count_up(count_up), .index_strobe(index_strobe), .host_wdata(host_wdata),
    .wr_mode(wr_mode), .wr_opts(wr_opts), .wr_preset(wr_preset),
    .clr_mode(clr_mode), .clr_opts(clr_opts), .clr_count(clr_count),
    .clr_status(clr_status), .load_count(load_count), .snap_count(snap_count),
    .count_val(count_val), .preset_val(preset_val), .snap_val(snap_val),
    .status_val(status_val), .mode_val(mode_val), .opts_val(opts_val),
    .latch_flag_n(latch_flag_n), .pulse_flag_n(pulse_flag_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Strobes are set at a falling edge; one rising edge acts; return at the next falling edge.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    count_strobe = 0; index_strobe = 0; wr_mode = 0; wr_opts = 0; wr_preset = 0;
    clr_mode = 0; clr_opts = 0; clr_count = 0; clr_status = 0; load_count = 0; snap_count = 0;
  endtask

  task automatic set_opts(input logic [7:0] v);   host_wdata = {24'h0, v}; wr_opts = 1; cyc(); endtask
  task automatic set_mode(input logic [7:0] v);   host_wdata = {24'h0, v}; wr_mode = 1; cyc(); endtask
  task automatic set_preset(input logic [31:0] v); host_wdata = v; wr_preset = 1; cyc(); endtask
  task automatic do_load();   load_count = 1; cyc(); endtask
  task automatic do_clrcnt(); clr_count = 1;  cyc(); endtask
  task automatic do_clrst();  clr_status = 1; cyc(); endtask
  task automatic step(input logic up); count_strobe = 1; count_up = up; cyc(); endtask
  task automatic do_index();  index_strobe = 1; cyc(); endtask

  task automatic t_reset();
    chk("R1 counter", count_val, 32'h0);
    chk("R1 preset", preset_val, 32'h0);
    chk("R1 snapshot", snap_val, 32'h0);
    chk("R1 status", {24'h0, status_val}, 32'h04);
    chk("R1 mode/opts", {16'h0, mode_val, opts_val}, 32'h0);
    chk("R1 flags", {30'h0, latch_flag_n, pulse_flag_n}, 32'h3);
  endtask

  task automatic t_free();
    set_opts(8'h03); set_mode(8'h00); set_preset(32'hFF); do_load();
    chk("R9 host load", count_val, 32'hFF);
    do_clrst();
    chk("R11 power-loss cleared", {31'h0, status_val[2]}, 32'h0);
    step(1);
    chk("R3 up wrap 1 byte", count_val, 32'h0);
    chk("R3 carry bit", {31'h0, status_val[7]}, 32'h1);
    step(0);
    chk("R3 down wrap 1 byte", count_val, 32'hFF);
    chk("R3 borrow bit", {31'h0, status_val[6]}, 32'h1);
    chk("R2 sign bit 1 byte", {31'h0, status_val[0]}, 32'h1);
    set_opts(8'h02);
    set_preset(32'h1234_5678);
    chk("R2 preset masked to 2 bytes", preset_val, 32'h5678);
    do_clrcnt(); step(0);
    chk("R2 down wrap 2 bytes", count_val, 32'hFFFF);
    chk("R2 sign bit 2 bytes", {31'h0, status_val[0]}, 32'h1);
    set_opts(8'h00); do_clrcnt(); step(0);
    chk("R2 down wrap 4 bytes", count_val, 32'hFFFF_FFFF);
  endtask

  task automatic t_single();
    set_opts(8'h03); set_mode(8'h04); set_preset(32'hFE); do_load(); do_clrst();
    step(1);
    chk("R4 counts before wrap", count_val, 32'hFF);
    step(1);
    chk("R4 wrap step taken", count_val, 32'h0);
    chk("R4 carry set", {31'h0, status_val[7]}, 32'h1);
    step(1);
    chk("R4 halted ignores up", count_val, 32'h0);
    step(0);
    chk("R4 halted ignores down", count_val, 32'h0);
    do_load(); step(1);
    chk("R4 load restarts counting", count_val, 32'hFF);
  endtask

  task automatic t_range();
    set_opts(8'h03); set_mode(8'h08); set_preset(32'h3); do_clrcnt(); do_clrst();
    step(1); step(1); step(1);
    chk("R5 reaches upper bound", count_val, 32'h3);
    chk("R5 no carry yet", {31'h0, status_val[7]}, 32'h0);
    step(1);
    chk("R5 freezes at preset", count_val, 32'h3);
    chk("R5 carry at freeze", {31'h0, status_val[7]}, 32'h1);
    step(0);
    chk("R5 resumes on reversal", count_val, 32'h2);
    do_clrcnt(); do_clrst(); step(0);
    chk("R5 freezes at zero", count_val, 32'h0);
    chk("R5 borrow at freeze", {31'h0, status_val[6]}, 32'h1);
    step(1);
    chk("R5 resumes up from zero", count_val, 32'h1);
  endtask

  task automatic t_modn();
    set_opts(8'h03); set_mode(8'h0C); set_preset(32'h2); do_clrcnt(); do_clrst();
    step(1); step(1);
    chk("R6 counts to preset", count_val, 32'h2);
    chk("R6 no carry before wrap", {31'h0, status_val[7]}, 32'h0);
    step(1);
    chk("R6 up wraps to zero", count_val, 32'h0);
    chk("R6 carry on wrap", {31'h0, status_val[7]}, 32'h1);
    do_clrst(); step(0);
    chk("R6 down wraps to preset", count_val, 32'h2);
    chk("R6 borrow on wrap", {31'h0, status_val[6]}, 32'h1);
  endtask

  task automatic t_enable();
    set_opts(8'h03); set_mode(8'h00); do_clrcnt();
    count_en = 0;
    step(1);
    chk("R7 pin low blocks count", count_val, 32'h0);
    chk("R7 status enable bit low", {31'h0, status_val[3]}, 32'h0);
    count_en = 1;
    set_opts(8'h07); step(1);
    chk("R7 inhibit bit blocks count", count_val, 32'h0);
    chk("R7 status enable bit inhibited", {31'h0, status_val[3]}, 32'h0);
    set_opts(8'h03); step(1);
    chk("R7 counting resumes", count_val, 32'h1);
    chk("R7 status enable bit high", {31'h0, status_val[3]}, 32'h1);
  endtask

  task automatic t_index();
    set_opts(8'h03); set_mode(8'h10); set_preset(32'h42); do_clrcnt(); do_clrst();
    do_index();
    chk("R8 index loads preset", count_val, 32'h42);
    chk("R8 index status bit", {31'h0, status_val[4]}, 32'h1);
    set_mode(8'h20); do_index();
    chk("R8 index clears counter", count_val, 32'h0);
    set_mode(8'h30); do_load(); do_index();
    chk("R8 index snapshot", snap_val, 32'h42);
    step(1);
    chk("R8 snapshot held while counting", {count_val[15:0], snap_val[15:0]}, 32'h0043_0042);
    set_mode(8'h00); do_clrst(); do_index();
    chk("R8 disabled index leaves counter", count_val, 32'h43);
    chk("R8 disabled index sets no status", {31'h0, status_val[4]}, 32'h0);
  endtask

  task automatic t_priority();
    set_opts(8'h03); set_mode(8'h00); set_preset(32'h42); do_load();
    clr_count = 1; load_count = 1; count_strobe = 1; count_up = 1; cyc();
    chk("R9 host clear beats load and step", count_val, 32'h0);
    set_mode(8'h20);
    load_count = 1; index_strobe = 1; cyc();
    chk("R9 host load beats index clear", count_val, 32'h42);
    set_mode(8'h10); do_clrcnt();
    index_strobe = 1; count_strobe = 1; count_up = 1; cyc();
    chk("R9 index load beats step", count_val, 32'h42);
    step(1); snap_count = 1; cyc();
    chk("R9 host snapshot", snap_val, 32'h43);
  endtask

  task automatic t_compare();
    set_opts(8'h03); set_mode(8'h00); set_preset(32'h5); do_load(); do_clrst();
    chk("R10 load raises no compare", {31'h0, status_val[5]}, 32'h0);
    step(0);
    chk("R10 no compare off preset", {31'h0, status_val[5]}, 32'h0);
    step(1);
    chk("R10 compare on reaching preset", {31'h0, status_val[5]}, 32'h1);
  endtask

  task automatic t_status();
    set_opts(8'h03); set_mode(8'h00); set_preset(32'hFF); do_load(); do_clrst();
    step(0);
    chk("R11 direction down", {31'h0, status_val[1]}, 32'h0);
    step(1);
    chk("R11 direction up", {31'h0, status_val[1]}, 32'h1);
    clr_status = 1; count_strobe = 1; count_up = 1; cyc();
    chk("R11 clear wins over carry", {24'h0, status_val[7:4], 1'b0, status_val[2], 2'b0}, 32'h0);
    chk("R11 step still taken", count_val, 32'h0);
    do_load(); step(1); step(1);
    chk("R11 carry stays sticky", {31'h0, status_val[7]}, 32'h1);
  endtask

  task automatic t_flags();
    set_opts(8'h83); set_mode(8'h00); set_preset(32'hFF); do_load(); do_clrst();
    chk("R12 flags idle", {30'h0, latch_flag_n, pulse_flag_n}, 32'h3);
    step(1);
    chk("R12 latched flag low on carry", {31'h0, latch_flag_n}, 32'h0);
    chk("R13 pulse low after carry", {31'h0, pulse_flag_n}, 32'h0);
    cyc();
    chk("R13 pulse ends after one cycle", {31'h0, pulse_flag_n}, 32'h1);
    chk("R12 latched flag held", {31'h0, latch_flag_n}, 32'h0);
    do_clrst();
    chk("R12 status clear releases flag", {31'h0, latch_flag_n}, 32'h1);
    step(0);
    chk("R12 masked borrow keeps flags high", {30'h0, latch_flag_n, pulse_flag_n}, 32'h3);
    set_opts(8'h43);
    chk("R12 enabling borrow shows latched borrow", {31'h0, latch_flag_n}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    count_en = 1;
    t_free();
    t_single();
    t_range();
    t_modn();
    t_enable();
    t_index();
    t_priority();
    t_compare();
    t_status();
    t_flags();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule